// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic datapath of a small microcontroller core with 14-bit instructions. Each cycle it takes the working register, a second operand (a file-register value or an immediate), an operation selector and a bit index. From these it produces a result word and a skip indication at once, with no clock in between. It also drives next values for the carry, half-carry and zero flags, and each of those flags has its own write-enable that depends on the operation.

The block holds the three flags itself in a small status register. The carry held there is the carry used by the rotates. The register loads only on a clock edge where `exec_en` is high, and only the flags whose write-enable is set change. The core routes `result` to its destination and uses `skip` to cancel the next instruction. Neither of those is part of this block.

Top module: `byte_alu`

## Requirements
- R1: After reset is applied, `status` reads 3'b000.
- R2: Add (op 1) gives W + operand, truncated to WIDTH bits. It loads C with the carry out of the top bit, HC with the carry out of bit 3, and Z with (result == 0).
- R3: Subtract (op 2) gives operand − W, computed as operand + ~W + 1. C becomes 1 when operand ≥ W, which means no borrow. HC becomes 1 when the low nibble of the operand is ≥ the low nibble of W. Z is loaded too.
- R4: Pass (op 0), AND (op 7), OR (op 8), XOR (op 9), complement of the operand (op 10) and clear (op 14) update Z only. C and HC keep their values.
- R5: Increment (op 3) and decrement (op 4) wrap modulo 2^WIDTH and update Z only.
- R6: Increment-skip (op 5) and decrement-skip (op 6) give the wrapped result and change no flag. `skip` is 1 exactly when the result is zero.
- R7: Rotate right (op 12) moves operand bit 0 into C and the held C into the top bit. Rotate left (op 13) moves the top bit into C and the held C into bit 0. Only C changes.
- R8: Swap (op 11) exchanges the upper and lower halves of the operand and changes no flag.
- R9: Bit set (op 15) and bit clear (op 16) force operand bit `bit_idx` to 1 or 0. No flag changes.
- R10: Test-skip-if-clear (op 17) raises `skip` when operand bit `bit_idx` is 0. Test-skip-if-set (op 18) raises `skip` when that bit is 1. Both pass the operand through and change no flag.
- R11: `status` holds C in bit 0, HC in bit 1 and Z in bit 2. It changes only on a clock edge where `exec_en` is 1.
- R12: Any selector value not listed above passes the operand through. It changes no flag and keeps `skip` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Commit the flag updates of this operation on the next edge |
| op_sel | input | 6 | Operation selector |
| w_in | input | WIDTH | Working register |
| opnd_in | input | WIDTH | File-register operand or immediate |
| bit_idx | input | IDXW | Bit index for the single-bit operations |
| result | output | WIDTH | Operation result |
| skip | output | 1 | Skip the next instruction |
| c_next | output | 1 | Next carry value |
| hc_next | output | 1 | Next half-carry value |
| z_next | output | 1 | Next zero value |
| c_we | output | 1 | Carry write-enable |
| hc_we | output | 1 | Half-carry write-enable |
| z_we | output | 1 | Zero write-enable |
| status | output | 3 | Held flags {Z, HC, C} |

## Verification
The bench builds the block with the default WIDTH of 8 and IDXW of 3, so a nibble is four bits. At that width the byte boundaries are easy to reach: 0xFF + 0x01 wraps to zero with both carries set, 0x00 − 0x01 borrows, and decrementing 0x01 reaches zero. Because the bit index covers bit 0 through bit 7, both the lowest and the highest bit are exercised in the set, clear and test operations. A reference model in the bench carries the flags from one operation to the next, so each carry feeds the following rotate, and the bench checks that a cycle with `exec_en` low leaves every flag alone.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int WIDTH = 8,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_en,
  input  logic [5:0]       op_sel,
  input  logic [WIDTH-1:0] w_in,
  input  logic [WIDTH-1:0] opnd_in,
  input  logic [IDXW-1:0]  bit_idx,
  output logic [WIDTH-1:0] result,
  output logic             skip,
  output logic             c_next,
  output logic             hc_next,
  output logic             z_next,
  output logic             c_we,
  output logic             hc_we,
  output logic             z_we,
  output logic [2:0]       status
);
  localparam int HALF = WIDTH / 2;

  localparam logic [5:0] OP_PASS  = 6'd0;
  localparam logic [5:0] OP_ADD   = 6'd1;
  localparam logic [5:0] OP_SUB   = 6'd2;
  localparam logic [5:0] OP_INC   = 6'd3;
  localparam logic [5:0] OP_DEC   = 6'd4;
  localparam logic [5:0] OP_INCSZ = 6'd5;
  localparam logic [5:0] OP_DECSZ = 6'd6;
  localparam logic [5:0] OP_AND   = 6'd7;
  localparam logic [5:0] OP_OR    = 6'd8;
  localparam logic [5:0] OP_XOR   = 6'd9;
  localparam logic [5:0] OP_COM   = 6'd10;
  localparam logic [5:0] OP_SWAP  = 6'd11;
  localparam logic [5:0] OP_RR    = 6'd12;
  localparam logic [5:0] OP_RL    = 6'd13;
  localparam logic [5:0] OP_CLR   = 6'd14;
  localparam logic [5:0] OP_BSET  = 6'd15;
  localparam logic [5:0] OP_BCLR  = 6'd16;
  localparam logic [5:0] OP_BTSC  = 6'd17;
  localparam logic [5:0] OP_BTSS  = 6'd18;

  logic             flag_c, flag_hc, flag_z;
  logic             is_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;
  logic [HALF:0]    hsum;
  logic [WIDTH-1:0] inc_v, dec_v, mask;

  assign is_sub = (op_sel == OP_SUB);
  assign addend = is_sub ? ~w_in : w_in;
  assign sum    = {1'b0, opnd_in} + {1'b0, addend} + {{WIDTH{1'b0}}, is_sub};
  assign hsum   = {1'b0, opnd_in[HALF-1:0]} + {1'b0, addend[HALF-1:0]} + {{HALF{1'b0}}, is_sub};
  assign inc_v  = opnd_in + 1'b1;
  assign dec_v  = opnd_in - 1'b1;
  assign mask   = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx;

  always_comb begin
    result  = opnd_in;
    skip    = 1'b0;
    c_next  = flag_c;
    hc_next = flag_hc;
    c_we    = 1'b0;
    hc_we   = 1'b0;
    z_we    = 1'b0;
    case (op_sel)
      OP_PASS: z_we = 1'b1;
      OP_ADD, OP_SUB: begin
        result  = sum[WIDTH-1:0];
        c_next  = sum[WIDTH];
        hc_next = hsum[HALF];
        c_we    = 1'b1;
        hc_we   = 1'b1;
        z_we    = 1'b1;
      end
      OP_INC:   begin result = inc_v; z_we = 1'b1; end
      OP_DEC:   begin result = dec_v; z_we = 1'b1; end
      OP_INCSZ: begin result = inc_v; skip = (inc_v == '0); end
      OP_DECSZ: begin result = dec_v; skip = (dec_v == '0); end
      OP_AND:   begin result = opnd_in & w_in; z_we = 1'b1; end
      OP_OR:    begin result = opnd_in | w_in; z_we = 1'b1; end
      OP_XOR:   begin result = opnd_in ^ w_in; z_we = 1'b1; end
      OP_COM:   begin result = ~opnd_in; z_we = 1'b1; end
      OP_SWAP:  result = {opnd_in[HALF-1:0], opnd_in[WIDTH-1:HALF]};
      OP_RR: begin
        result = {flag_c, opnd_in[WIDTH-1:1]};
        c_next = opnd_in[0];
        c_we   = 1'b1;
      end
      OP_RL: begin
        result = {opnd_in[WIDTH-2:0], flag_c};
        c_next = opnd_in[WIDTH-1];
        c_we   = 1'b1;
      end
      OP_CLR:  begin result = '0; z_we = 1'b1; end
      OP_BSET: result = opnd_in | mask;
      OP_BCLR: result = opnd_in & ~mask;
      OP_BTSC: skip = ((opnd_in & mask) == '0);
      OP_BTSS: skip = ((opnd_in & mask) != '0);
      default: ;
    endcase
  end

  assign z_next = (result == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c  <= 1'b0;
      flag_hc <= 1'b0;
      flag_z  <= 1'b0;
    end else if (exec_en) begin
      if (c_we)  flag_c  <= c_next;
      if (hc_we) flag_hc <= hc_next;
      if (z_we)  flag_z  <= z_next;
    end
  end

  assign status = {flag_z, flag_hc, flag_c};

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(status));

  a_r11_zero_commit: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && z_we |=> status[2] == ($past(result) == '0));

  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == OP_ADD |=>
      status[0] == ((({1'b0, $past(w_in)} + {1'b0, $past(opnd_in)}) >> WIDTH) != 0));

  a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == OP_SUB |=> status[0] == ($past(opnd_in) >= $past(w_in)));

  a_r6_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (op_sel == OP_INCSZ || op_sel == OP_DECSZ || op_sel == OP_BTSC || op_sel == OP_BTSS));

  a_r7_carry_only_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    c_we && !hc_we |-> (op_sel == OP_RR || op_sel == OP_RL) && !z_we);
endmodule

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [5:0] op_sel = '0;
  logic [7:0] w_in = '0;
  logic [7:0] opnd_in = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] result;
  logic       skip, c_next, hc_next, z_next, c_we, hc_we, z_we;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  bit driver_done = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic       skp;
    logic [2:0] st;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic mc = 1'b0, mhc = 1'b0, mz = 1'b0;

  always #10 clk = ~clk;

  byte_alu dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .w_in(w_in), .opnd_in(opnd_in), .bit_idx(bit_idx),
    .result(result), .skip(skip), .c_next(c_next), .hc_next(hc_next),
    .z_next(z_next), .c_we(c_we), .hc_we(hc_we), .z_we(z_we), .status(status)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] op, input logic [7:0] w, input logic [7:0] r,
                        input logic [2:0] idx, input logic en, input string tag);
    exp_t e;
    logic [7:0] res = r;
    logic sk = 1'b0;
    logic nc = mc, nhc = mhc, nz = mz;
    logic uz = 1'b0;
    @(posedge clk);
    #1;
    op_sel = op; w_in = w; opnd_in = r; bit_idx = idx; exec_en = en;
    case (op)
      6'd0: uz = 1'b1;
      6'd1: begin
        res = w + r; nc = (int'(w) + int'(r)) > 255;
        nhc = (int'(w[3:0]) + int'(r[3:0])) > 15; uz = 1'b1;
      end
      6'd2: begin
        res = r - w; nc = (r >= w); nhc = (r[3:0] >= w[3:0]); uz = 1'b1;
      end
      6'd3: begin res = r + 8'd1; uz = 1'b1; end
      6'd4: begin res = r - 8'd1; uz = 1'b1; end
      6'd5: begin res = r + 8'd1; sk = (res == 8'd0); end
      6'd6: begin res = r - 8'd1; sk = (res == 8'd0); end
      6'd7: begin res = r & w; uz = 1'b1; end
      6'd8: begin res = r | w; uz = 1'b1; end
      6'd9: begin res = r ^ w; uz = 1'b1; end
      6'd10: begin res = ~r; uz = 1'b1; end
      6'd11: res = {r[3:0], r[7:4]};
      6'd12: begin res = {mc, r[7:1]}; nc = r[0]; end
      6'd13: begin res = {r[6:0], mc}; nc = r[7]; end
      6'd14: begin res = 8'd0; uz = 1'b1; end
      6'd15: res[idx] = 1'b1;
      6'd16: res[idx] = 1'b0;
      6'd17: sk = (r[idx] == 1'b0);
      6'd18: sk = (r[idx] == 1'b1);
      default: ;
    endcase
    if (uz) nz = (res == 8'd0);
    e.res = res; e.skp = sk; e.st = {mz, mhc, mc}; e.tag = tag;
    q.push_back(e);
    if (en) begin mc = nc; mhc = nhc; mz = nz; end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "result", result, e.res);
        check(e.tag, "skip", skip, e.skp);
        check("R11", "status", status, e.st);
      end
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check("R1", "status after reset", status, 0);
    rst_n = 1'b1;
    run_op(6'd1, 8'h0F, 8'h01, 3'd0, 1'b1, "R2");
    run_op(6'd1, 8'hFF, 8'h01, 3'd0, 1'b1, "R2");
    run_op(6'd1, 8'h80, 8'h90, 3'd0, 1'b1, "R2");
    run_op(6'd2, 8'h03, 8'h05, 3'd0, 1'b1, "R3");
    run_op(6'd2, 8'h01, 8'h00, 3'd0, 1'b1, "R3");
    run_op(6'd2, 8'h18, 8'h21, 3'd0, 1'b1, "R3");
    run_op(6'd2, 8'h42, 8'h42, 3'd0, 1'b1, "R3");
    run_op(6'd7, 8'hF0, 8'h0F, 3'd0, 1'b1, "R4");
    run_op(6'd8, 8'hA0, 8'h05, 3'd0, 1'b1, "R4");
    run_op(6'd9, 8'h5A, 8'h5A, 3'd0, 1'b1, "R4");
    run_op(6'd10, 8'h00, 8'hFF, 3'd0, 1'b1, "R4");
    run_op(6'd14, 8'h00, 8'h77, 3'd0, 1'b1, "R4");
    run_op(6'd0, 8'h00, 8'h3C, 3'd0, 1'b1, "R4");
    run_op(6'd3, 8'h00, 8'hFF, 3'd0, 1'b1, "R5");
    run_op(6'd4, 8'h00, 8'h00, 3'd0, 1'b1, "R5");
    run_op(6'd4, 8'h00, 8'h01, 3'd0, 1'b1, "R5");
    run_op(6'd5, 8'h00, 8'hFF, 3'd0, 1'b1, "R6");
    run_op(6'd5, 8'h00, 8'h10, 3'd0, 1'b1, "R6");
    run_op(6'd6, 8'h00, 8'h01, 3'd0, 1'b1, "R6");
    run_op(6'd6, 8'h00, 8'h00, 3'd0, 1'b1, "R6");
    run_op(6'd1, 8'h01, 8'hFF, 3'd0, 1'b1, "R2");
    run_op(6'd12, 8'h00, 8'h02, 3'd0, 1'b1, "R7");
    run_op(6'd12, 8'h00, 8'h81, 3'd0, 1'b1, "R7");
    run_op(6'd13, 8'h00, 8'h40, 3'd0, 1'b1, "R7");
    run_op(6'd13, 8'h00, 8'h80, 3'd0, 1'b1, "R7");
    run_op(6'd13, 8'h00, 8'h00, 3'd0, 1'b1, "R7");
    run_op(6'd11, 8'h00, 8'hA5, 3'd0, 1'b1, "R8");
    run_op(6'd11, 8'h00, 8'h00, 3'd0, 1'b1, "R8");
    run_op(6'd15, 8'h00, 8'h00, 3'd7, 1'b1, "R9");
    run_op(6'd15, 8'h00, 8'h10, 3'd0, 1'b1, "R9");
    run_op(6'd16, 8'h00, 8'hFF, 3'd0, 1'b1, "R9");
    run_op(6'd16, 8'h00, 8'h80, 3'd7, 1'b1, "R9");
    run_op(6'd17, 8'h00, 8'hFE, 3'd0, 1'b1, "R10");
    run_op(6'd17, 8'h00, 8'h80, 3'd7, 1'b1, "R10");
    run_op(6'd18, 8'h00, 8'h80, 3'd7, 1'b1, "R10");
    run_op(6'd18, 8'h00, 8'h7F, 3'd7, 1'b1, "R10");
    run_op(6'd1, 8'hFF, 8'hFF, 3'd0, 1'b0, "R11");
    run_op(6'd14, 8'h00, 8'h55, 3'd0, 1'b0, "R11");
    run_op(6'd63, 8'h12, 8'h9C, 3'd0, 1'b1, "R12");
    run_op(6'd40, 8'h00, 8'h00, 3'd0, 1'b1, "R12");
    run_op(6'd63, 8'h00, 8'h00, 3'd0, 1'b0, "R11");
    @(posedge clk);
    @(posedge clk);
    driver_done = 1'b1;
  end

  initial begin : watchdog
    int cycles = 0;
    while (!(driver_done && q.size() == 0) && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule